// File: doc/BRIEF.md
# Two-Channel Avionics Word Buffer with Halfword Readout

This block holds the most recent 32-bit word delivered by each of two serial word receivers and presents it to a host as two 16-bit halfwords. Each receiver pulses an end-of-word strobe with its completed word. An optional label-side filter compares word positions 9 and 10 with two programmed match bits. An accepted word is latched into that channel's holding register, and the channel's active-low ready output is driven low.

The host reads a channel by raising that channel's read enable. While the enable is high, a shared half selector chooses the low or high halfword, and the result appears on one 16-bit output bus. A read is counted on the rising edge of the enable. The ready flag returns high only after both halves have been counted. A newer accepted word replaces an unread one and restarts the two-half requirement.

Each channel is a four-state machine:
- `CH_EMPTY`: nothing unread; ready high.
- `CH_FULL`: new word, no half read yet.
- `CH_LO_DONE`: low half read.
- `CH_HI_DONE`: high half read.

The transitions are:
- `accept` (any state to `CH_FULL`) on an accepted strobe. This transition has priority over all others.
- `read_lo` (`CH_FULL` to `CH_LO_DONE`).
- `read_hi` (`CH_FULL` to `CH_HI_DONE`).
- `finish` (`CH_LO_DONE` to `CH_EMPTY` on a high-half read, or `CH_HI_DONE` to `CH_EMPTY` on a low-half read).
- `repeat` (a read of an already counted half, which leaves the state unchanged).

Top module: `arx_word_buffer`

## Requirements
- R1: After reset, both `ready_n` bits are 1, and `dout` is 0 while no read enable is high.
- R2: With `dec_en` = 0, every strobe on `eos[c]` latches `word_in` for channel c, and `ready_n[c]` is 0 from the following clock edge.
- R3: With `dec_en` = 1, a word is accepted only if word bit 8 equals `dec_bits[0]` and word bit 9 equals `dec_bits[1]` (word bit k is position k+1). A rejected word changes neither `ready_n[c]` nor the held word.
- R4: While `rd_en[c]` is high, `dout` shows bits 15:0 of the channel's held word when `half_sel` = 0, and bits 31:16 when `half_sel` = 1.
- R5: `ready_n[c]` returns to 1 at the clock edge that samples the rising edge of `rd_en[c]` completing the second distinct half. The two halves may be read in either order.
- R6: Reading the same half twice does not clear `ready_n[c]`. Holding `rd_en[c]` high counts as a single read.
- R7: A newly accepted word overwrites an unread or partly read word, and restarts the two-half read requirement.
- R8: When an accepted strobe and a completing read edge occur in the same cycle, the new word wins: it is latched and `ready_n[c]` stays 0.
- R9: The channels operate independently. If both enables are high, channel 0 drives `dout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_en | input | 1 | Enables the position 9/10 match filter |
| dec_bits | input | 2 | Match values; [0] is for word bit 8, [1] is for word bit 9 |
| eos | input | 2 | Per-channel end-of-word strobe |
| word_in | input | 64 | Per-channel word; channel c is at [32c+31:32c] |
| rd_en | input | 2 | Per-channel read enable |
| half_sel | input | 1 | 0 selects the low halfword, 1 selects the high halfword |
| dout | output | 16 | Halfword output; 0 when no enable is high |
| ready_n | output | 2 | Per-channel active-low data-ready flag |

## Verification
The accept transition and the finish transition can occur in the same cycle on one channel. The bench provokes this by reading one half of a word first. It then raises the enable for the other half on the same falling edge that presents a new word with its strobe. It judges the outcome by requiring that the flag stays low and that both halves of the new word then read back before the flag clears.

// File: rtl/arx_pkg.sv
package arx_pkg;
    typedef enum logic [1:0] {
        CH_EMPTY   = 2'd0,
        CH_FULL    = 2'd1,
        CH_LO_DONE = 2'd2,
        CH_HI_DONE = 2'd3
    } ch_state_e;
endpackage

// File: rtl/arx_channel.sv
module arx_channel
    import arx_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int DEC_LSB = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_en,
    input  logic [1:0]        dec_bits,
    input  logic              eos,
    input  logic [WORD_W-1:0] word_in,
    input  logic              rd_en,
    input  logic              half_sel,
    output logic [WORD_W-1:0] word_q,
    output logic              ready_n
);
    ch_state_e state_q, state_d;
    logic      rd_en_q;
    logic      rd_rise;
    logic      accept;

    assign rd_rise = rd_en && !rd_en_q;
    assign accept  = eos && (!dec_en || (word_in[DEC_LSB+1:DEC_LSB] == dec_bits));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_EMPTY;
            rd_en_q <= 1'b0;
            word_q  <= '0;
        end else begin
            state_q <= state_d;
            rd_en_q <= rd_en;
            if (accept) word_q <= word_in;
        end
    end

    always_comb begin
        state_d = state_q;
        if (accept) begin
            state_d = CH_FULL;
        end else if (rd_rise) begin
            unique case (state_q)
                CH_EMPTY:   state_d = CH_EMPTY;
                CH_FULL:    state_d = half_sel ? CH_HI_DONE : CH_LO_DONE;
                CH_LO_DONE: state_d = half_sel ? CH_EMPTY : CH_LO_DONE;
                CH_HI_DONE: state_d = half_sel ? CH_HI_DONE : CH_EMPTY;
                default:    state_d = CH_EMPTY;
            endcase
        end
    end

    always_comb begin
        ready_n = (state_q == CH_EMPTY);
    end

    // R3
    rejected_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && dec_en && (word_in[DEC_LSB+1:DEC_LSB] != dec_bits)) |=> $stable(word_q));
    // R2
    accepted_word_latched_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eos && !dec_en) |=> (!ready_n && word_q == $past(word_in)));
    // R5
    flag_clears_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> $past(rd_en && !rd_en_q));
    // R6
    single_half_keeps_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_FULL && !eos) |=> !ready_n);
endmodule

// File: rtl/arx_out_mux.sv
module arx_out_mux #(
    parameter int NCH    = 2,
    parameter int WORD_W = 32
) (
    input  logic [NCH*WORD_W-1:0] words,
    input  logic [NCH-1:0]        rd_en,
    input  logic                  half_sel,
    output logic [WORD_W/2-1:0]   dout
);
    localparam int HALF_W = WORD_W / 2;

    always_comb begin
        dout = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (rd_en[i]) begin
                dout = half_sel ? words[i*WORD_W+HALF_W +: HALF_W]
                                : words[i*WORD_W +: HALF_W];
            end
        end
    end
endmodule

// File: rtl/arx_word_buffer.sv
module arx_word_buffer #(
    parameter int NCH     = 2,
    parameter int WORD_W  = 32,
    parameter int DEC_LSB = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_en,
    input  logic [1:0]            dec_bits,
    input  logic [NCH-1:0]        eos,
    input  logic [NCH*WORD_W-1:0] word_in,
    input  logic [NCH-1:0]        rd_en,
    input  logic                  half_sel,
    output logic [WORD_W/2-1:0]   dout,
    output logic [NCH-1:0]        ready_n
);
    localparam int HALF_W = WORD_W / 2;

    logic [NCH*WORD_W-1:0] held;

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        arx_channel #(.WORD_W(WORD_W), .DEC_LSB(DEC_LSB)) ch_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .dec_en   (dec_en),
            .dec_bits (dec_bits),
            .eos      (eos[c]),
            .word_in  (word_in[c*WORD_W +: WORD_W]),
            .rd_en    (rd_en[c]),
            .half_sel (half_sel),
            .word_q   (held[c*WORD_W +: WORD_W]),
            .ready_n  (ready_n[c])
        );
    end

    arx_out_mux #(.NCH(NCH), .WORD_W(WORD_W)) mux_i (
        .words    (held),
        .rd_en    (rd_en),
        .half_sel (half_sel),
        .dout     (dout)
    );

    // R1
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en == '0) |-> (dout == '0));
    // R9
    ch0_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en[0] && !half_sel) |-> (dout == held[HALF_W-1:0]));
endmodule

// File: tb/arx_word_buffer_tb.sv
module arx_word_buffer_tb_top;
    typedef struct packed {
        logic        ch;
        logic        den;
        logic [1:0]  dbits;
        logic [31:0] word;
        logic        acc;
    } vec_t;

    localparam vec_t VECS [6] = '{
        '{1'b0, 1'b0, 2'b00, 32'hA5A5_0300, 1'b1},
        '{1'b1, 1'b1, 2'b11, 32'h1234_0300, 1'b1},
        '{1'b1, 1'b1, 2'b01, 32'h5555_0300, 1'b0},
        '{1'b0, 1'b1, 2'b10, 32'hDEAD_0200, 1'b1},
        '{1'b0, 1'b1, 2'b00, 32'hFFFF_FEFF, 1'b0},
        '{1'b1, 1'b1, 2'b00, 32'h0F0F_00FF, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_en = 1'b0;
    logic [1:0]  dec_bits = 2'b00;
    logic [1:0]  eos = 2'b00;
    logic [63:0] word_in = '0;
    logic [1:0]  rd_en = 2'b00;
    logic        half_sel = 1'b0;
    logic [15:0] dout;
    logic [1:0]  ready_n;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] exp_word [2];

    always #4 clk = ~clk;

    arx_word_buffer dut_i (
        .clk(clk), .rst_n(rst_n), .dec_en(dec_en), .dec_bits(dec_bits),
        .eos(eos), .word_in(word_in), .rd_en(rd_en), .half_sel(half_sel),
        .dout(dout), .ready_n(ready_n)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic strobe(input int c, input logic [31:0] w);
        @(negedge clk);
        eos[c] = 1'b1;
        word_in[c*32 +: 32] = w;
        @(negedge clk);
        eos = 2'b00;
    endtask

    task automatic read_half(input int c, input logic hs, input logic [15:0] exp, input string req);
        @(negedge clk);
        rd_en[c] = 1'b1;
        half_sel = hs;
        #1;
        chk(dout === exp, req, {16'h0, dout}, {16'h0, exp});
        @(negedge clk);
        rd_en = 2'b00;
    endtask

    initial begin
        #400000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        exp_word[0] = '0;
        exp_word[1] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(ready_n === 2'b11, "R1", {30'h0, ready_n}, 32'h3);
        chk(dout === 16'h0, "R1", {16'h0, dout}, 32'h0);

        // R2 R3 R4 R5 table walk
        foreach (VECS[k]) begin
            automatic vec_t v = VECS[k];
            automatic int c = int'(v.ch);
            dec_en = v.den;
            dec_bits = v.dbits;
            strobe(c, v.word);
            if (v.acc) exp_word[c] = v.word;
            chk(ready_n[c] === !v.acc, v.den ? "R3" : "R2", {31'h0, ready_n[c]}, {31'h0, !v.acc});
            if (k % 2 == 0) begin
                read_half(c, 1'b0, exp_word[c][15:0], "R4");
                read_half(c, 1'b1, exp_word[c][31:16], "R4");
            end else begin
                read_half(c, 1'b1, exp_word[c][31:16], "R4");
                read_half(c, 1'b0, exp_word[c][15:0], "R4");
            end
            chk(ready_n[c] === 1'b1, "R5", {31'h0, ready_n[c]}, 32'h1);
        end
        dec_en = 1'b0;

        // R6 same half twice, and held enable
        strobe(0, 32'hCAFE_BEEF);
        read_half(0, 1'b0, 16'hBEEF, "R4");
        read_half(0, 1'b0, 16'hBEEF, "R4");
        chk(ready_n[0] === 1'b0, "R6", {31'h0, ready_n[0]}, 32'h0);
        @(negedge clk);
        rd_en[0] = 1'b1;
        half_sel = 1'b0;
        @(negedge clk);
        half_sel = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk(ready_n[0] === 1'b0, "R6", {31'h0, ready_n[0]}, 32'h0);
        rd_en = 2'b00;
        read_half(0, 1'b1, 16'hCAFE, "R4");
        chk(ready_n[0] === 1'b1, "R6", {31'h0, ready_n[0]}, 32'h1);

        // R7 overwrite partly read word
        strobe(1, 32'h1111_2222);
        read_half(1, 1'b0, 16'h2222, "R4");
        strobe(1, 32'h3333_4444);
        read_half(1, 1'b1, 16'h3333, "R7");
        chk(ready_n[1] === 1'b0, "R7", {31'h0, ready_n[1]}, 32'h0);
        read_half(1, 1'b0, 16'h4444, "R7");
        chk(ready_n[1] === 1'b1, "R7", {31'h0, ready_n[1]}, 32'h1);

        // R8 strobe and completing read in one cycle
        strobe(0, 32'hAAAA_5555);
        read_half(0, 1'b0, 16'h5555, "R4");
        @(negedge clk);
        rd_en[0] = 1'b1;
        half_sel = 1'b1;
        eos[0] = 1'b1;
        word_in[31:0] = 32'h7777_8888;
        @(negedge clk);
        eos = 2'b00;
        rd_en = 2'b00;
        chk(ready_n[0] === 1'b0, "R8", {31'h0, ready_n[0]}, 32'h0);
        read_half(0, 1'b0, 16'h8888, "R8");
        read_half(0, 1'b1, 16'h7777, "R8");
        chk(ready_n[0] === 1'b1, "R8", {31'h0, ready_n[0]}, 32'h1);

        // R9 independence and priority
        strobe(1, 32'h9999_6666);
        chk(ready_n === 2'b01, "R9", {30'h0, ready_n}, 32'h1);
        @(negedge clk);
        rd_en = 2'b11;
        half_sel = 1'b1;
        #1;
        chk(dout === 16'h7777, "R9", {16'h0, dout}, 32'h7777);
        @(negedge clk);
        rd_en = 2'b00;
        #1;
        chk(dout === 16'h0, "R1", {16'h0, dout}, 32'h0);
        chk(ready_n[0] === 1'b1, "R9", {31'h0, ready_n[0]}, 32'h1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule